// File: doc/BRIEF.md
# Serial NOR Flash Device Model

This block is the device end of a serial NOR flash, built as synthesizable logic around a small on-chip byte array. A host drives the serial clock in SPI mode 0 and frames each transaction with an active-low select. The block samples the clock, select and data lines with its own system clock, puts the incoming bits together into bytes and decodes a fixed set of opcodes. It answers on the serial output with identification bytes or array contents.

Program and erase follow NOR rules. Programming can only clear bits, and erasing sets bytes back to 0xFF. Neither takes effect unless a write-enable latch was set beforehand. Addresses are 3 bytes long after reset. An opcode switches them to 4 bytes, and a two-opcode software reset switches them back. Address bits above the array size are dropped, so the array appears again at higher addresses. Erases sweep the array at one byte per system clock after the frame closes. The host must leave the select high until a sweep has finished.

Top module: `spi_nor_dev`

## Requirements
- R1: Opcode 0x9F answers with the bytes 0x20, 0xBA and 0x19 in that order, and with 0x00 for every further byte of the frame.
- R2: Opcode 0x03, followed by an address sent most significant byte first, streams array bytes starting at that address. The address rises by one per byte while select stays low, and address bits above the array size are ignored.
- R3: Opcode 0x02, followed by an address and data bytes, stores each data byte ANDed with the old contents. After the last byte of a 256-byte page the address wraps to the start of the same page.
- R4: Opcodes 0x02, 0xD8 and 0xC7 change nothing in the array unless the write-enable latch is set.
- R5: Opcode 0x06 sets the write-enable latch. The latch clears when any frame that carried 0x02, 0xD8 or 0xC7 ends, whether or not that command completed.
- R6: Opcode 0xD8 with an address sets the whole sector holding that address to 0xFF (1024 bytes by default). Opcode 0xC7 sets the whole array to 0xFF. Bytes outside the erased range keep their values.
- R7: Opcode 0xB7 makes every later address phase 4 bytes long.
- R8: Opcode 0x66 followed by 0x99, as the next opcode in the same frame or in a later frame, returns to 3-byte addresses and clears the write-enable latch. Any other opcode between the two cancels the sequence.
- R9: An opcode outside the decoded set makes the block ignore the rest of the frame, and the serial output stays 0 until select rises.
- R10: After 0x06, 0xB7, 0x66 or 0x99, the next byte in the same frame is decoded as a new opcode.
- R11: After reset, addresses are 3 bytes long, the latch is clear and the serial output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the serial lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock, idle low, data sampled on its rising edge |
| cs_ni | input | 1 | Active-low chip select that frames a transaction |
| mosi_i | input | 1 | Serial data from the host, MSB first |
| miso_o | output | 1 | Serial data to the host, changed after falling clock edges |

## Verification
A wrong latch or address-mode state gives no sign at the port where it occurs. It shows up only in the next frame that depends on it: a program that lands or does not land, or a read that consumes one address byte too many or too few and so returns the wrong byte. Each scenario therefore reads the array back straight after the frame under test. A bad address counter or page wrap shows in the first data byte that crosses the boundary. A broken erase range shows only when the neighbouring sector is read after the sweep time has passed.

// File: rtl/spi_nor_pkg.sv
package spi_nor_pkg;
  typedef logic [7:0] byte_t;

  localparam byte_t OPC_IDENT  = 8'h9F;
  localparam byte_t OPC_READ   = 8'h03;
  localparam byte_t OPC_PROG   = 8'h02;
  localparam byte_t OPC_SECT   = 8'hD8;
  localparam byte_t OPC_BULK   = 8'hC7;
  localparam byte_t OPC_WEN    = 8'h06;
  localparam byte_t OPC_ADDR4  = 8'hB7;
  localparam byte_t OPC_RSTARM = 8'h66;
  localparam byte_t OPC_RSTGO  = 8'h99;

  localparam byte_t ID_BYTE0 = 8'h20;
  localparam byte_t ID_BYTE1 = 8'hBA;
  localparam byte_t ID_BYTE2 = 8'h19;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_ADDR,
    ST_READ,
    ST_PROG,
    ST_IDENT,
    ST_SKIP
  } cmd_state_e;
endpackage

// File: rtl/spi_nor_link.sv
module spi_nor_link
  import spi_nor_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sck_i,
  input  logic  cs_ni,
  input  logic  mosi_i,
  input  byte_t tx_byte_i,
  output logic  byte_valid_o,
  output byte_t byte_o,
  output logic  frame_end_o,
  output logic  miso_o
);
  logic [2:0] sck_q;
  logic [1:0] cs_q;
  logic [1:0] mosi_q;
  logic       cs_d;
  logic [2:0] bit_cnt_q;
  logic [6:0] rx_q;
  byte_t      tx_q;

  logic cs_s, mosi_s, rise, fall;
  assign cs_s   = cs_q[1];
  assign mosi_s = mosi_q[1];
  assign rise   = sck_q[1] & ~sck_q[2] & ~cs_s;
  assign fall   = ~sck_q[1] & sck_q[2] & ~cs_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q  <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
      cs_d   <= 1'b1;
    end else begin
      sck_q  <= {sck_q[1:0], sck_i};
      cs_q   <= {cs_q[0], cs_ni};
      mosi_q <= {mosi_q[0], mosi_i};
      cs_d   <= cs_s;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      rx_q      <= '0;
    end else if (cs_s) begin
      bit_cnt_q <= '0;
    end else if (rise) begin
      bit_cnt_q <= bit_cnt_q + 3'd1;
      rx_q      <= {rx_q[5:0], mosi_s};
    end
  end

  // byte boundary falling edge loads, the others shift
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            tx_q <= '0;
    else if (cs_s)          tx_q <= '0;
    else if (fall) begin
      if (bit_cnt_q == 3'd0) tx_q <= tx_byte_i;
      else                   tx_q <= {tx_q[6:0], 1'b0};
    end
  end

  assign byte_valid_o = rise && (bit_cnt_q == 3'd7);
  assign byte_o       = {rx_q, mosi_s};
  assign frame_end_o  = cs_s & ~cs_d;
  assign miso_o       = tx_q[7];
endmodule

// File: rtl/spi_nor_array.sv
module spi_nor_array #(
  parameter int MEM_BYTES    = 2048,
  parameter int SECTOR_BYTES = 1024,
  localparam int AW          = $clog2(MEM_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic          erase_go_i,
  input  logic          erase_all_i,
  input  logic [AW-1:0] erase_addr_i
);
  localparam logic [AW-1:0] SEC_MASK = AW'(SECTOR_BYTES - 1);

  logic [7:0]    mem_q [MEM_BYTES];
  logic          busy_q;
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
      last_q <= '0;
    end else if (erase_go_i) begin
      busy_q <= 1'b1;
      ptr_q  <= erase_all_i ? '0 : (erase_addr_i & ~SEC_MASK);
      last_q <= erase_all_i ? '1 : (erase_addr_i | SEC_MASK);
    end else if (busy_q) begin
      if (ptr_q == last_q) busy_q <= 1'b0;
      else                 ptr_q  <= ptr_q + AW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (busy_q)       mem_q[ptr_q]     <= 8'hFF;
    else if (wr_en_i) mem_q[wr_addr_i] <= mem_q[wr_addr_i] & wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];

  a_r6_sweep_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !erase_go_i && ptr_q == last_q) |=> !busy_q);
endmodule

// File: rtl/spi_nor_cmd.sv
module spi_nor_cmd
  import spi_nor_pkg::*;
#(
  parameter int AW         = 11,
  parameter int PAGE_BYTES = 256,
  localparam int PW        = $clog2(PAGE_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          byte_valid_i,
  input  byte_t         byte_i,
  input  logic          frame_end_i,
  output byte_t         tx_byte_o,
  output logic [AW-1:0] rd_addr_o,
  input  byte_t         rd_data_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output byte_t         wr_data_o,
  output logic          erase_go_o,
  output logic          erase_all_o,
  output logic [AW-1:0] erase_addr_o
);
  cmd_state_e    state_q;
  byte_t         op_q;
  logic [AW-1:0] addr_q;
  logic [1:0]    acnt_q;
  logic [1:0]    id_idx_q;
  logic          wel_q, addr4_q, armed_q, pe_frame_q, erase_req_q, erase_all_q, fetch_q;
  byte_t         tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_OPC;
      op_q        <= '0;
      addr_q      <= '0;
      acnt_q      <= '0;
      id_idx_q    <= '0;
      wel_q       <= 1'b0;
      addr4_q     <= 1'b0;
      armed_q     <= 1'b0;
      pe_frame_q  <= 1'b0;
      erase_req_q <= 1'b0;
      erase_all_q <= 1'b0;
      fetch_q     <= 1'b0;
      tx_q        <= '0;
    end else if (frame_end_i) begin
      state_q     <= ST_OPC;
      pe_frame_q  <= 1'b0;
      erase_req_q <= 1'b0;
      fetch_q     <= 1'b0;
      tx_q        <= '0;
      if (pe_frame_q) wel_q <= 1'b0;
    end else if (byte_valid_i) begin
      fetch_q <= 1'b0;
      unique case (state_q)
        ST_OPC: begin
          armed_q <= (byte_i == OPC_RSTARM);
          tx_q    <= '0;
          case (byte_i)
            OPC_IDENT: begin
              state_q  <= ST_IDENT;
              tx_q     <= ID_BYTE0;
              id_idx_q <= 2'd1;
            end
            OPC_READ, OPC_PROG, OPC_SECT: begin
              state_q <= ST_ADDR;
              op_q    <= byte_i;
              acnt_q  <= addr4_q ? 2'd3 : 2'd2;
              if (byte_i != OPC_READ) pe_frame_q <= 1'b1;
            end
            OPC_BULK: begin
              state_q     <= ST_SKIP;
              pe_frame_q  <= 1'b1;
              erase_req_q <= 1'b1;
              erase_all_q <= 1'b1;
            end
            OPC_WEN:    wel_q   <= 1'b1;
            OPC_ADDR4:  addr4_q <= 1'b1;
            OPC_RSTARM: ;
            OPC_RSTGO: begin
              if (armed_q) begin
                addr4_q <= 1'b0;
                wel_q   <= 1'b0;
              end
            end
            default: state_q <= ST_SKIP;
          endcase
        end
        ST_ADDR: begin
          addr_q <= {addr_q[AW-9:0], byte_i};
          acnt_q <= acnt_q - 2'd1;
          if (acnt_q == 2'd0) begin
            if (op_q == OPC_READ) begin
              state_q <= ST_READ;
              fetch_q <= 1'b1;
            end else if (op_q == OPC_PROG) begin
              state_q <= ST_PROG;
            end else begin
              state_q     <= ST_SKIP;
              erase_req_q <= 1'b1;
              erase_all_q <= 1'b0;
            end
          end
        end
        ST_READ: fetch_q <= 1'b1;
        ST_PROG: addr_q <= {addr_q[AW-1:PW], addr_q[PW-1:0] + PW'(1)};
        ST_IDENT: begin
          case (id_idx_q)
            2'd1:    tx_q <= ID_BYTE1;
            2'd2:    tx_q <= ID_BYTE2;
            default: tx_q <= '0;
          endcase
          if (id_idx_q != 2'd3) id_idx_q <= id_idx_q + 2'd1;
        end
        default: ;
      endcase
    end else if (fetch_q) begin
      fetch_q <= 1'b0;
      tx_q    <= rd_data_i;
      addr_q  <= addr_q + AW'(1);
    end
  end

  assign tx_byte_o    = tx_q;
  assign rd_addr_o    = addr_q;
  assign wr_en_o      = byte_valid_i && !frame_end_i && state_q == ST_PROG && wel_q;
  assign wr_addr_o    = addr_q;
  assign wr_data_o    = byte_i;
  assign erase_go_o   = frame_end_i && wel_q && erase_req_q;
  assign erase_all_o  = erase_all_q;
  assign erase_addr_o = addr_q;

  a_r5_wel_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_i && pe_frame_q) |=> !wel_q);
  a_r8_reset_seq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && !frame_end_i && state_q == ST_OPC && byte_i == OPC_RSTGO && armed_q)
      |=> (!wel_q && !addr4_q));
  a_r3_page_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> addr_q[AW-1:PW] == $past(addr_q[AW-1:PW]));
  a_r7_addr4_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addr4_q) |-> $past(byte_valid_i && byte_i == OPC_ADDR4));
  a_r9_skip_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SKIP) |-> tx_q == 8'h00);
  a_r1_id_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDENT) |-> id_idx_q != 2'd0);
endmodule

// File: rtl/spi_nor_dev.sv
module spi_nor_dev #(
  parameter int MEM_BYTES    = 2048,
  parameter int SECTOR_BYTES = 1024,
  parameter int PAGE_BYTES   = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic miso_o
);
  import spi_nor_pkg::*;
  localparam int AW = $clog2(MEM_BYTES);

  logic          byte_valid, frame_end;
  byte_t         rx_byte, tx_byte, rd_data, wr_data;
  logic [AW-1:0] rd_addr, wr_addr, erase_addr;
  logic          wr_en, erase_go, erase_all;

  spi_nor_link u_link (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sck_i       (sck_i),
    .cs_ni       (cs_ni),
    .mosi_i      (mosi_i),
    .tx_byte_i   (tx_byte),
    .byte_valid_o(byte_valid),
    .byte_o      (rx_byte),
    .frame_end_o (frame_end),
    .miso_o      (miso_o)
  );

  spi_nor_cmd #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_cmd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_valid_i(byte_valid),
    .byte_i      (rx_byte),
    .frame_end_i (frame_end),
    .tx_byte_o   (tx_byte),
    .rd_addr_o   (rd_addr),
    .rd_data_i   (rd_data),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .erase_go_o  (erase_go),
    .erase_all_o (erase_all),
    .erase_addr_o(erase_addr)
  );

  spi_nor_array #(.MEM_BYTES(MEM_BYTES), .SECTOR_BYTES(SECTOR_BYTES)) u_array (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_addr_i   (rd_addr),
    .rd_data_o   (rd_data),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .erase_go_i  (erase_go),
    .erase_all_i (erase_all),
    .erase_addr_i(erase_addr)
  );
endmodule

// File: tb/spi_nor_dev_test.sv
module spi_nor_dev_test;
  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  spi_nor_dev uut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi), .miso_o(miso)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      tick(8);
      rx[i] = miso;
      sck = 1'b1;
      tick(8);
      sck = 1'b0;
    end
  endtask

  task automatic put(input logic [7:0] tx);
    logic [7:0] d;
    xfer(tx, d);
  endtask

  task automatic sel();
    cs_n = 1'b0;
    tick(8);
  endtask

  task automatic desel();
    tick(8);
    cs_n = 1'b1;
    tick(16);
  endtask

  task automatic cmd1(input logic [7:0] op);
    sel(); put(op); desel();
  endtask

  task automatic send_addr(input logic [31:0] a, input bit four);
    if (four) put(a[31:24]);
    put(a[23:16]); put(a[15:8]); put(a[7:0]);
  endtask

  task automatic read_chk(input string req, input logic [31:0] a, input bit four,
                          input int n, input logic [31:0] exp);
    logic [7:0] r;
    sel(); put(8'h03); send_addr(a, four);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, r);
      check8(req, r, exp[8*(n-1-k) +: 8]);
    end
    desel();
  endtask

  task automatic prog(input logic [31:0] a, input bit four, input int n, input logic [31:0] d);
    sel(); put(8'h02); send_addr(a, four);
    for (int k = 0; k < n; k++) put(d[8*(n-1-k) +: 8]);
    desel();
  endtask

  task automatic t_reset();
    check8("R11 miso idle", {7'b0, miso}, 8'h00);
    rst_n = 1'b1;
    tick(4);
    check8("R11 miso after reset", {7'b0, miso}, 8'h00);
  endtask

  task automatic t_bulk();
    cmd1(8'h06); cmd1(8'hC7); tick(2200);
    read_chk("R6 bulk low", 32'h000000, 1'b0, 4, 32'hFFFFFFFF);
    read_chk("R6 bulk high R11", 32'h0007FE, 1'b0, 2, 32'h0000FFFF);
  endtask

  task automatic t_ident();
    logic [7:0] r;
    logic [39:0] exp = 40'h20BA190000;
    sel(); put(8'h9F);
    for (int k = 0; k < 5; k++) begin
      xfer(8'h00, r);
      check8("R1 ident", r, exp[8*(4-k) +: 8]);
    end
    desel();
  endtask

  task automatic t_program();
    cmd1(8'h06); prog(32'h000100, 1'b0, 4, 32'hA53C0FF0);
    read_chk("R3 program", 32'h000100, 1'b0, 4, 32'hA53C0FF0);
    cmd1(8'h06); prog(32'h000100, 1'b0, 4, 32'hF0F0FF0F);
    read_chk("R3 and", 32'h000100, 1'b0, 4, 32'hA0300F00);
    cmd1(8'h06); prog(32'h0001FE, 1'b0, 3, 32'h00112233);
    read_chk("R2 stream across page", 32'h0001FE, 1'b0, 3, 32'h001122FF);
    read_chk("R3 page wrap", 32'h000100, 1'b0, 1, 32'h00000020);
    read_chk("R2 upper bits ignored", 32'hFF0900, 1'b0, 1, 32'h00000020);
  endtask

  task automatic t_wel();
    prog(32'h000300, 1'b0, 1, 32'h0);
    read_chk("R4 program without latch", 32'h000300, 1'b0, 1, 32'h000000FF);
    cmd1(8'h06); cmd1(8'h02);
    prog(32'h000301, 1'b0, 1, 32'h0);
    read_chk("R5 latch cleared by bare frame", 32'h000301, 1'b0, 1, 32'h000000FF);
    cmd1(8'h06); cmd1(8'h02);
    sel(); put(8'hD8); send_addr(32'h000100, 1'b0); desel(); tick(1100);
    read_chk("R4 erase without latch", 32'h000100, 1'b0, 1, 32'h00000020);
  endtask

  task automatic t_chain();
    sel(); put(8'h06); put(8'h02); send_addr(32'h000310, 1'b0); put(8'h5A); desel();
    read_chk("R10 chained latch and program", 32'h000310, 1'b0, 1, 32'h0000005A);
    prog(32'h000311, 1'b0, 1, 32'h00000066);
    read_chk("R5 latch cleared after program", 32'h000311, 1'b0, 1, 32'h000000FF);
  endtask

  task automatic t_sector();
    cmd1(8'h06); prog(32'h000400, 1'b0, 1, 32'h00000055);
    read_chk("R3 program sector1", 32'h000400, 1'b0, 1, 32'h00000055);
    cmd1(8'h06);
    sel(); put(8'hD8); send_addr(32'h000405, 1'b0); desel(); tick(1100);
    read_chk("R6 sector erased", 32'h000400, 1'b0, 1, 32'h000000FF);
    read_chk("R6 other sector kept", 32'h000100, 1'b0, 1, 32'h00000020);
  endtask

  task automatic t_unknown();
    logic [7:0] r;
    sel(); put(8'h5A);
    put(8'h03); put(8'h00); put(8'h01);
    for (int k = 0; k < 3; k++) begin
      xfer(8'h00, r);
      check8("R9 unknown opcode silent", r, 8'h00);
    end
    desel();
    read_chk("R9 next frame decoded", 32'h000100, 1'b0, 1, 32'h00000020);
  endtask

  task automatic t_addr_mode();
    cmd1(8'hB7);
    read_chk("R7 four byte read", 32'h00000100, 1'b1, 2, 32'h00002030);
    cmd1(8'h66);
    read_chk("R8 disarm frame", 32'h00000100, 1'b1, 1, 32'h00000020);
    cmd1(8'h99);
    read_chk("R8 cancelled sequence", 32'h00000101, 1'b1, 1, 32'h00000030);
    cmd1(8'h06); cmd1(8'h66); cmd1(8'h99);
    read_chk("R8 three byte after reset", 32'h000100, 1'b0, 1, 32'h00000020);
    prog(32'h000320, 1'b0, 1, 32'h0);
    read_chk("R8 latch cleared by reset", 32'h000320, 1'b0, 1, 32'h000000FF);
    cmd1(8'hB7);
    sel(); put(8'h66); put(8'h99); desel();
    read_chk("R8 same frame reset", 32'h000101, 1'b0, 1, 32'h00000030);
  endtask

  initial begin
    tick(5);
    t_reset();
    t_bulk();
    t_ident();
    t_program();
    t_wel();
    t_chain();
    t_sector();
    t_unknown();
    t_addr_mode();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule